// File: doc/BRIEF.md
# Differential Clock Output Enable Controller

This block decides, for each of four differential clock output pairs, whether the pair is driven or left in high impedance. It combines two pin-level pair enables, a global stop input, a power-down input and a shared polarity-invert input with a per-pair enable bit held in a small register. A pair is driven only when all of these sources agree.

The combined request for each pair passes through a two-flop synchronizer clocked by the input clock. It is then captured on the falling edge, so every start and stop falls inside the clock's low phase. The block also drives a gated copy of the input clock for each pair, which the analog drivers can follow. The PLL-or-bypass select and the bandwidth select pass straight through as control outputs.

Top module: `clkoe_ctrl`

## Requirements
- R1: While rst_ni is low and right after reset, drv_en_o and clk_gated_o are all 0, and every register enable bit holds 1. With the register untouched, the pins alone decide which pairs are driven.
- R2: With inv_i = 0, oe_pin_i bit 0 enables pair 0 and oe_pin_i bit 3 enables pair 3, both active high (1 = enable).
- R3: With inv_i = 0, stop_pin_i = 0 or pdn_pin_i = 0 turns all four pairs off, whatever the other inputs are.
- R4: With inv_i = 1, oe_pin_i bits 0 and 3, stop_pin_i and pdn_pin_i are all read with inverted polarity: pin enable active at 0, stop active at 1, power-down active at 1.
- R5: Pairs 1 and 2 have no pin enable. oe_pin_i bits 1 and 2 have no effect on any output.
- R6: A write (reg_wr_i = 1 at a rising edge) loads reg_wdata_i into the register, with bit i enabling pair i. A 0 bit turns its pair off even when every pin allows it.
- R7: While power-down is active, register writes are ignored. The register keeps its old value, and that value becomes visible once power-down is released.
- R8: A change in a pair's combined request shows on drv_en_o at the falling edge that follows the second rising edge after the change.
- R9: clk_gated_o[i] equals clk_i while pair i is enabled and is 0 otherwise. Enable changes happen only while clk_i is low, so no shortened pulse appears.
- R10: pll_mode_o follows pll_mode_i and bw_sel_o follows bw_sel_i at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input reference clock; also clocks the control logic |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_pin_i | input | 4 | Pin enables; bits 0 and 3 are used |
| stop_pin_i | input | 1 | Global stop pin (active low when inv_i = 0) |
| pdn_pin_i | input | 1 | Power-down pin (active low when inv_i = 0) |
| inv_i | input | 1 | Polarity invert for the enable, stop and power-down pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 4 | Register write data, one enable bit per pair |
| pll_mode_i | input | 1 | PLL / bypass select in |
| bw_sel_i | input | 1 | PLL bandwidth select in |
| drv_en_o | output | 4 | Per-pair drive enable (0 = tri-state) |
| clk_gated_o | output | 4 | Per-pair gated clock |
| pll_mode_o | output | 1 | PLL / bypass select out |
| bw_sel_o | output | 1 | PLL bandwidth select out |

## Verification
The bench builds the block with its defaults: four pairs, a pin mask on pairs 0 and 3, and two synchronizer stages. With these values both pin-less pairs and both pin-controlled pairs are exercised under each polarity. The two-stage latency is short enough that every request change can be checked at the exact falling edge where it lands. Holding power-down for a few cycles is enough to show a blocked write, and then to release power-down and observe the retained value.

// File: rtl/clkoe_pkg.sv
package clkoe_pkg;
  localparam int unsigned NUM_PAIRS_DEF = 4;
  localparam int unsigned SYNC_DEF      = 2;

  typedef struct packed {
    logic stop;
    logic pdn;
  } halt_t;

  function automatic logic pin_used(input int unsigned mask, input int unsigned idx);
    return ((mask >> idx) & 1) != 0;
  endfunction
endpackage

// File: rtl/clkoe_polarity.sv
module clkoe_polarity
  import clkoe_pkg::*;
#(
  parameter int unsigned NP = NUM_PAIRS_DEF
) (
  input  logic [NP-1:0] oe_pin_i,
  input  logic          stop_pin_i,
  input  logic          pdn_pin_i,
  input  logic          inv_i,
  output logic [NP-1:0] oe_act_o,
  output halt_t         halt_o
);
  // inv_i = 0: enables active high, stop/pdn active low
  assign oe_act_o    = oe_pin_i ^ {NP{inv_i}};
  assign halt_o.stop = stop_pin_i ^ ~inv_i;
  assign halt_o.pdn  = pdn_pin_i ^ ~inv_i;
endmodule

// File: rtl/clkoe_regs.sv
module clkoe_regs #(
  parameter int unsigned NP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pdn_i,
  input  logic          wr_i,
  input  logic [NP-1:0] wdata_i,
  output logic [NP-1:0] en_o
);
  logic [NP-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            en_q <= '1;
    else if (wr_i && !pdn_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  AST_PDN_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && pdn_i) |=> $stable(en_q)); // R7
  AST_WR_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !pdn_i) |=> en_q == $past(wdata_i)); // R6
endmodule

// File: rtl/clkoe_sync.sv
module clkoe_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkoe_gate.sv
module clkoe_gate #(
  parameter int unsigned NP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] req_i,
  output logic [NP-1:0] en_o,
  output logic [NP-1:0] clk_o
);
  logic [NP-1:0] en_q;

  for (genvar i = 0; i < NP; i++) begin : g_pair
    // capture in low phase only
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[i] <= 1'b0;
      else         en_q[i] <= req_i[i];
    end
    assign clk_o[i] = clk_i & en_q[i];
  end

  assign en_o = en_q;

  // had en_q moved on the rising edge it would lag req_i here
  AST_LOW_PHASE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == req_i); // R9
endmodule

// File: rtl/clkoe_ctrl.sv
module clkoe_ctrl
  import clkoe_pkg::*;
#(
  parameter int unsigned NUM_PAIRS   = NUM_PAIRS_DEF,
  parameter int unsigned PIN_MASK    = 32'h9,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PAIRS-1:0] oe_pin_i,
  input  logic                 stop_pin_i,
  input  logic                 pdn_pin_i,
  input  logic                 inv_i,
  input  logic                 reg_wr_i,
  input  logic [NUM_PAIRS-1:0] reg_wdata_i,
  input  logic                 pll_mode_i,
  input  logic                 bw_sel_i,
  output logic [NUM_PAIRS-1:0] drv_en_o,
  output logic [NUM_PAIRS-1:0] clk_gated_o,
  output logic                 pll_mode_o,
  output logic                 bw_sel_o
);
  localparam int unsigned CW = $clog2(SYNC_STAGES + 1) + 1;

  logic [NUM_PAIRS-1:0] oe_act, reg_en, req, req_sync;
  halt_t                halt;

  clkoe_polarity #(.NP(NUM_PAIRS)) i_pol (
    .oe_pin_i  (oe_pin_i),
    .stop_pin_i(stop_pin_i),
    .pdn_pin_i (pdn_pin_i),
    .inv_i     (inv_i),
    .oe_act_o  (oe_act),
    .halt_o    (halt)
  );

  clkoe_regs #(.NP(NUM_PAIRS)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pdn_i  (halt.pdn),
    .wr_i   (reg_wr_i),
    .wdata_i(reg_wdata_i),
    .en_o   (reg_en)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_req
    if (pin_used(PIN_MASK, i)) begin : g_pin
      assign req[i] = reg_en[i] & oe_act[i] & ~halt.stop & ~halt.pdn;
    end else begin : g_nopin
      assign req[i] = reg_en[i] & ~halt.stop & ~halt.pdn;
    end
  end

  clkoe_sync #(.WIDTH(NUM_PAIRS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req),
    .q_o   (req_sync)
  );

  clkoe_gate #(.NP(NUM_PAIRS)) i_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_sync),
    .en_o  (drv_en_o),
    .clk_o (clk_gated_o)
  );

  assign pll_mode_o = pll_mode_i;
  assign bw_sel_o   = bw_sel_i;

  // consecutive halted rising edges, saturating
  logic [CW-1:0] halt_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          halt_cnt_q <= '0;
    else if (!(halt.stop || halt.pdn))    halt_cnt_q <= '0;
    else if (halt_cnt_q < CW'(SYNC_STAGES)) halt_cnt_q <= halt_cnt_q + 1'b1;
  end

  AST_HALT_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_cnt_q >= CW'(SYNC_STAGES)) |-> drv_en_o == '0); // R3
endmodule

// File: tb/test_clkoe_ctrl.sv
`timescale 1ns/100ps
module test_clkoe_ctrl;
  localparam int NP = 4;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic [NP-1:0] oe_pin_i = 4'b1001;
  logic          stop_pin_i = 1, pdn_pin_i = 1, inv_i = 0;
  logic          reg_wr_i = 0;
  logic [NP-1:0] reg_wdata_i = '0;
  logic          pll_mode_i = 0, bw_sel_i = 0;
  logic [NP-1:0] drv_en_o, clk_gated_o;
  logic          pll_mode_o, bw_sel_o;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  clkoe_ctrl i_clkoe_ctrl (.*);

  // reference model
  int m_reg = 4'hF, m_s1 = 0, m_s2 = 0, m_en = 0;

  function automatic int model_req();
    int r = 0;
    bit halted, pdn_on;
    halted = inv_i ? stop_pin_i : !stop_pin_i;
    pdn_on = inv_i ? pdn_pin_i  : !pdn_pin_i;
    for (int i = 0; i < NP; i++) begin
      bit pin_ok = 1;
      if (i == 0 || i == 3) pin_ok = inv_i ? !oe_pin_i[i] : oe_pin_i[i];
      if (m_reg[i] && pin_ok && !halted && !pdn_on) r |= (1 << i);
    end
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_reg = 4'hF;
    end else begin
      bit pdn_on;
      pdn_on = inv_i ? pdn_pin_i : !pdn_pin_i;
      m_s2 = m_s1;
      m_s1 = model_req();
      if (reg_wr_i && !pdn_on) m_reg = reg_wdata_i;
    end
  end

  always @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_en = 0;
    else         m_en = m_s2;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-edge comparison
  always @(posedge clk_i) begin
    #0.5;
    check(drv_en_o == NP'(m_en), cur_req, drv_en_o, m_en);
    check(clk_gated_o == NP'(m_en), "R9", clk_gated_o, m_en);
    check({pll_mode_o, bw_sel_o} == {pll_mode_i, bw_sel_i}, "R10",
          {pll_mode_o, bw_sel_o}, {pll_mode_i, bw_sel_i});
  end
  always @(negedge clk_i) begin
    #0.5;
    check(drv_en_o == NP'(m_en), cur_req, drv_en_o, m_en);
    check(clk_gated_o == '0, "R9", clk_gated_o, 0);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
    #1.5;
  endtask

  task automatic wr(input logic [NP-1:0] d);
    reg_wr_i = 1; reg_wdata_i = d;
    step(1);
    reg_wr_i = 0;
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    cur_req = "R1";
    #5;
    check(drv_en_o == '0 && clk_gated_o == '0, "R1", drv_en_o, 0);
    step(2);
    rst_ni = 1;
    step(6);
    check(drv_en_o == 4'hF, "R1", drv_en_o, 4'hF);

    cur_req = "R2";
    oe_pin_i = 4'b1000; step(5);
    check(drv_en_o == 4'b1110, "R2", drv_en_o, 4'b1110);
    oe_pin_i = 4'b0001; step(5);
    check(drv_en_o == 4'b0111, "R2", drv_en_o, 4'b0111);

    cur_req = "R5";
    oe_pin_i = 4'b0000; step(5);
    check(drv_en_o == 4'b0110, "R5", drv_en_o, 4'b0110);
    oe_pin_i = 4'b1111; step(5);
    check(drv_en_o == 4'b1111, "R5", drv_en_o, 4'b1111);

    cur_req = "R8";
    oe_pin_i = 4'b1000;
    @(posedge clk_i); #0.5;
    check(drv_en_o[0] == 1, "R8", drv_en_o[0], 1);
    @(posedge clk_i); #0.5;
    check(drv_en_o[0] == 1, "R8", drv_en_o[0], 1);
    @(negedge clk_i); #0.5;
    check(drv_en_o[0] == 0, "R8", drv_en_o[0], 0);
    oe_pin_i = 4'b1001; step(4);

    cur_req = "R3";
    stop_pin_i = 0; step(5);
    check(drv_en_o == '0, "R3", drv_en_o, 0);
    stop_pin_i = 1; pdn_pin_i = 0; step(5);
    check(drv_en_o == '0, "R3", drv_en_o, 0);
    pdn_pin_i = 1; step(5);

    cur_req = "R4";
    inv_i = 1; oe_pin_i = 4'b0000; stop_pin_i = 0; pdn_pin_i = 0; step(5);
    check(drv_en_o == 4'hF, "R4", drv_en_o, 4'hF);
    oe_pin_i = 4'b1001; step(5);
    check(drv_en_o == 4'b0110, "R4", drv_en_o, 4'b0110);
    stop_pin_i = 1; step(5);
    check(drv_en_o == '0, "R4", drv_en_o, 0);
    stop_pin_i = 0; pdn_pin_i = 1; step(5);
    check(drv_en_o == '0, "R4", drv_en_o, 0);
    inv_i = 0; oe_pin_i = 4'b1001; stop_pin_i = 1; pdn_pin_i = 1; step(5);

    cur_req = "R6";
    wr(4'b1010); step(4);
    check(drv_en_o == 4'b1010, "R6", drv_en_o, 4'b1010);

    cur_req = "R7";
    pdn_pin_i = 0; step(2);
    wr(4'b0101); step(2);
    pdn_pin_i = 1; step(5);
    check(drv_en_o == 4'b1010, "R7", drv_en_o, 4'b1010);
    wr(4'b1111); step(4);

    cur_req = "R10";
    pll_mode_i = 1; step(1);
    bw_sel_i = 1; step(1);
    pll_mode_i = 0; step(1);

    cur_req = "R9";
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      oe_pin_i   = lfsr[3:0];
      stop_pin_i = inv_i ^ (lfsr[6:4] != 0);
      pdn_pin_i  = inv_i ^ (lfsr[9:7] != 0);
      if (lfsr[15:13] == 0) inv_i = ~inv_i;
      reg_wr_i    = (lfsr[12:10] == 3'd5);
      reg_wdata_i = lfsr[11:8];
      pll_mode_i  = lfsr[1];
      bw_sel_i    = lfsr[2];
      step(1 + lfsr[0]);
    end
    reg_wr_i = 0;
    step(4);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule